// File: doc/BRIEF.md
# Programmable Square-Wave Divider

This block derives a square wave from a low-frequency oscillator. The oscillator is presented as a one-cycle strobe, `half_tick`, that fires on every edge of the 32.768 kHz source, so it fires at 65536 strobes per second. A 4-bit rate code selects a power-of-two output frequency between 32768 Hz and 1 Hz. An enable bit, kept in a different register, gates the output. Whenever the block is disabled or the code is zero, the output is forced low.

Both settings are loaded through the same register write port that the timekeeping core uses. The rate code sits in bits 7:4 of register 4; the low bits of that register belong to the weekday field and do not affect this block. The enable is bit 6 of register 0xA; the other bits of that register belong to the alarm logic. Any write to register 4 restarts the divider with the output low, even when the written value equals the old one. Software should therefore skip redundant writes to register 4 if it must not disturb the phase of the wave.

Top module: `sqw_gen`

## Requirements
- R1: While `rst` is high, `sq_out` is 0. After reset the rate code is 1 and the enable is set, so the output starts toggling on the first strobe after reset is released.
- R2: With code 1, the output toggles on every strobe: the half period is 1 strobe, giving 32768 Hz.
- R3: With code 2, the half period is 4 strobes, giving 8192 Hz.
- R4: With a code n from 3 to 15, the half period is 2^n strobes, giving 2^(15-n) Hz. Code 15 gives 1 Hz.
- R5: With code 0, `sq_out` is held low.
- R6: The enable is bit 6 of register 0xA. While it is 0, `sq_out` is held low from the cycle after the write. Setting it again restarts the count from zero with the output low, so the first rise comes a full half period later.
- R7: Writing register 0xA with bit 6 set does not disturb the running wave, whatever its other bits hold; bit 7 in particular has no effect on the output.
- R8: Any write to register 4 clears the divider and drives `sq_out` low on the next clock edge. This holds even when the value is unchanged, and even when a strobe arrives in the same cycle. The first rise then follows a full half period later.
- R9: Bits 3:0 of register 4 do not change the rate, and writes to addresses other than 4 and 0xA have no effect on the output.
- R10: `sq_out` changes only on a clock edge that carries a strobe, except when the output is forced low by a restart, a disable or code 0. The wave has a 50% duty cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| half_tick | input | 1 | One-cycle strobe on every edge of the 32.768 kHz source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| sq_out | output | 1 | Registered square-wave output |

## Verification
Two events can fall in the same clock cycle: a write to the rate register and a source strobe. The rate-register write restarts the divider, while the strobe would advance the count or toggle the output. The bench holds the strobe high on every cycle while it rewrites register 4, including with an unchanged value in the middle of a high phase. It expects the output low on the edge of the write, and the next rise exactly one half period of strobes later, which shows that the restart took priority over the strobe. The bench also times half periods while the strobe stalls or arrives only on alternate cycles, to check that the output counts strobes rather than clocks.

// File: rtl/sqw_pkg.sv
package sqw_pkg;

  // Half-period exponent (in source-edge strobes) for a rate code.
  // Code 1 runs at the full source rate, code 2 skips two octaves,
  // codes 3 and above map linearly onto the exponent.
  function automatic int unsigned code_to_exp(input int unsigned code);
    if (code == 1)
      return 0;
    else if (code == 2)
      return 2;
    else
      return code;
  endfunction

endpackage

// File: rtl/sqw_regs.sv
module sqw_regs #(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned RATE_W   = 4,
  parameter int unsigned RATE_LSB = 4,
  parameter int unsigned EN_BIT   = 6,
  parameter logic [ADDR_W-1:0] RATE_ADDR = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 10,
  parameter logic [RATE_W-1:0] RATE_RST  = 1,
  parameter logic              EN_RST    = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [RATE_W-1:0] rate_code,
  output logic              out_en,
  output logic              rate_wr
);

  logic rate_hit;
  logic ctrl_hit;
  logic [RATE_W-1:0] code_q;
  logic              en_q;
  logic              unused_wdata;

  assign rate_hit = wr_en && (wr_addr == RATE_ADDR);
  assign ctrl_hit = wr_en && (wr_addr == CTRL_ADDR);

  // Only the rate nibble and the enable bit matter here; the other bits
  // belong to neighbouring functions.
  assign unused_wdata = ^wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= RATE_RST;
      en_q   <= EN_RST;
    end else begin
      if (rate_hit)
        code_q <= wr_data[RATE_LSB +: RATE_W];
      if (ctrl_hit)
        en_q <= wr_data[EN_BIT];
    end
  end

  assign rate_code = code_q;
  assign out_en    = en_q;
  assign rate_wr   = rate_hit;

endmodule

// File: rtl/sqw_decode.sv
module sqw_decode
  import sqw_pkg::*;
#(
  parameter int unsigned RATE_W = 4,
  parameter int unsigned DIV_W  = 15
) (
  input  logic [RATE_W-1:0] rate_code,
  output logic [DIV_W-1:0]  term,
  output logic              code_live
);

  localparam int unsigned N_CODES = 1 << RATE_W;

  logic [DIV_W-1:0] term_tab [N_CODES];

  // One terminal count per code; the table collapses to constants.
  for (genvar g = 0; g < N_CODES; g++) begin : g_term
    assign term_tab[g] = DIV_W'((64'd1 << code_to_exp(g)) - 64'd1);
  end

  assign term      = term_tab[rate_code];
  assign code_live = (rate_code != '0);

endmodule

// File: rtl/sqw_divider.sv
module sqw_divider #(
  parameter int unsigned DIV_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic             tick,
  input  logic [DIV_W-1:0] term,
  output logic             sq_out
);

  logic [DIV_W-1:0] cnt_q;
  logic             wave_q;

  // Restart and idle share the clear path; a strobe in the same cycle
  // as a restart is dropped.
  always_ff @(posedge clk) begin
    if (rst || !run || restart) begin
      cnt_q  <= '0;
      wave_q <= 1'b0;
    end else if (tick) begin
      if (cnt_q >= term) begin
        cnt_q  <= '0;
        wave_q <= ~wave_q;
      end else begin
        cnt_q <= cnt_q + DIV_W'(1);
      end
    end
  end

  assign sq_out = wave_q;

endmodule

// File: rtl/sqw_gen.sv
module sqw_gen #(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned RATE_W   = 4,
  parameter int unsigned RATE_LSB = 4,
  parameter int unsigned EN_BIT   = 6,
  parameter logic [ADDR_W-1:0] RATE_ADDR = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              half_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              sq_out
);

  localparam int unsigned DIV_W = (1 << RATE_W) - 1;

  logic [RATE_W-1:0] rate_code;
  logic              out_en;
  logic              rate_wr;
  logic [DIV_W-1:0]  term;
  logic              code_live;

  sqw_regs #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .RATE_W   (RATE_W),
    .RATE_LSB (RATE_LSB),
    .EN_BIT   (EN_BIT),
    .RATE_ADDR(RATE_ADDR),
    .CTRL_ADDR(CTRL_ADDR),
    .RATE_RST (RATE_W'(1)),
    .EN_RST   (1'b1)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rate_code(rate_code),
    .out_en   (out_en),
    .rate_wr  (rate_wr)
  );

  sqw_decode #(
    .RATE_W(RATE_W),
    .DIV_W (DIV_W)
  ) u_decode (
    .rate_code(rate_code),
    .term     (term),
    .code_live(code_live)
  );

  sqw_divider #(
    .DIV_W(DIV_W)
  ) u_div (
    .clk    (clk),
    .rst    (rst),
    .run    (out_en && code_live),
    .restart(rate_wr),
    .tick   (half_tick),
    .term   (term),
    .sq_out (sq_out)
  );

endmodule

// File: rtl/sqw_gen_chk.sv
module sqw_gen_chk #(
  parameter int unsigned RATE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              rate_wr,
  input logic [RATE_W-1:0] rate_code,
  input logic              out_en,
  input logic              sq_out
);

  // R8: a rate-register write forces the output low on the next edge
  a_r8_restart_low: assert property (@(posedge clk) disable iff (rst)
    rate_wr |=> !sq_out);

  // R5: code zero holds the output low
  a_r5_code_zero_low: assert property (@(posedge clk) disable iff (rst)
    (rate_code == '0) |=> !sq_out);

  // R6: a cleared enable holds the output low
  a_r6_disabled_low: assert property (@(posedge clk) disable iff (rst)
    !out_en |=> !sq_out);

  // R10: without a strobe or restart, the output may only fall (forced low)
  a_r10_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    (!tick && !rate_wr) |=> ($stable(sq_out) || !sq_out));

  // R10: a rising output needs a strobe in the previous cycle
  a_r10_rise_needs_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(sq_out) |-> $past(tick));

endmodule

bind sqw_gen sqw_gen_chk #(.RATE_W(RATE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (half_tick),
  .rate_wr  (rate_wr),
  .rate_code(rate_code),
  .out_en   (out_en),
  .sq_out   (sq_out)
);

// File: tb/sqw_gen_test.sv
`timescale 1ns/1ps
module sqw_gen_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       half_tick = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       sq_out;

  int n_chk = 0;
  int n_err = 0;
  int tick_mode = 0;   // 0: strobe every cycle, 1: no strobe, 2: alternate
  bit finished = 1'b0;

  sqw_gen uut (
    .clk      (clk),
    .rst      (rst),
    .half_tick(half_tick),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .sq_out   (sq_out)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    case (tick_mode)
      0:       half_tick <= 1'b1;
      1:       half_tick <= 1'b0;
      default: half_tick <= ~half_tick;
    endcase
  end

  task automatic check(input string req, input int actual, input int expected);
    n_chk++;
    if (actual !== expected) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [7:0] d);
    wr_addr = a;
    wr_data = d;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  // Count negedges until sq_out reaches lvl.
  task automatic cycles_to(input logic lvl, input int limit, output int n);
    n = 0;
    while (sq_out !== lvl && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    int n;
    repeat (3) @(negedge clk);
    check("R1 output low in reset", int'(sq_out), 0);
    rst = 1'b0;
    cycles_to(1'b1, 10, n);
    check("R1 first rise after reset", n, 1);
    cycles_to(1'b0, 10, n);
    check("R2 default half period", n, 1);
  endtask

  task automatic t_rate(input logic [3:0] code, input int half, input string req);
    int n;
    reg_write(4'h4, {code, 4'h0});
    check({req, " low after rate write"}, int'(sq_out), 0);
    cycles_to(1'b1, half + 10, n);
    check({req, " first rise"}, n, half);
    if (half < 1000) begin
      cycles_to(1'b0, half + 10, n);
      check({req, " high phase"}, n, half);
      cycles_to(1'b1, half + 10, n);
      check({req, " low phase"}, n, half);
    end
  endtask

  task automatic t_code_zero();
    int highs = 0;
    reg_write(4'h4, 8'h00);
    repeat (100) begin
      @(negedge clk);
      if (sq_out) highs++;
    end
    check("R5 code zero holds low", highs, 0);
  endtask

  task automatic t_enable();
    int n;
    int highs = 0;
    reg_write(4'h4, 8'h30);
    cycles_to(1'b1, 20, n);
    reg_write(4'hA, 8'h00);
    @(negedge clk);
    check("R6 low after disable", int'(sq_out), 0);
    repeat (50) begin
      @(negedge clk);
      if (sq_out) highs++;
    end
    check("R6 held low while disabled", highs, 0);
    reg_write(4'hA, 8'h40);
    cycles_to(1'b1, 20, n);
    check("R6 re-enable restarts from zero", n, 8);
  endtask

  // At a rising edge, write a register that must not disturb the phase.
  task automatic t_no_disturb(input logic [3:0] a, input logic [7:0] d, input string req);
    int n;
    reg_write(4'h4, 8'h30);
    cycles_to(1'b1, 20, n);
    reg_write(a, d);
    cycles_to(1'b0, 20, n);
    check(req, n + 1, 8);
  endtask

  task automatic t_same_rewrite();
    int n;
    reg_write(4'h4, 8'h30);
    cycles_to(1'b1, 20, n);
    repeat (3) @(negedge clk);
    check("R8 high before rewrite", int'(sq_out), 1);
    reg_write(4'h4, 8'h30);
    check("R8 same-value rewrite drops output", int'(sq_out), 0);
    cycles_to(1'b1, 20, n);
    check("R8 full half period after restart", n, 8);
  endtask

  task automatic t_low_nibble();
    int n;
    reg_write(4'h4, 8'h37);
    cycles_to(1'b1, 20, n);
    check("R9 weekday bits ignored first rise", n, 8);
    cycles_to(1'b0, 20, n);
    check("R9 weekday bits ignored high phase", n, 8);
  endtask

  task automatic t_tick_gate();
    int n;
    logic held;
    int changes = 0;
    reg_write(4'h4, 8'h30);
    cycles_to(1'b1, 20, n);
    tick_mode = 1;
    repeat (2) @(negedge clk);
    held = sq_out;
    repeat (40) begin
      @(negedge clk);
      if (sq_out !== held) changes++;
    end
    check("R10 output holds without strobes", changes, 0);
    tick_mode = 2;
    repeat (3) @(negedge clk);
    cycles_to(~sq_out, 40, n);
    cycles_to(~sq_out, 40, n);
    check("R10 half period counts strobes not clocks", n, 16);
    tick_mode = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_rate(4'd1, 1, "R2 code 1");
    t_rate(4'd2, 4, "R3 code 2");
    t_rate(4'd3, 8, "R4 code 3");
    t_rate(4'd5, 32, "R4 code 5");
    t_rate(4'd15, 32768, "R4 code 15");
    t_code_zero();
    t_enable();
    t_no_disturb(4'hA, 8'hC0, "R7 alarm-enable bit has no effect");
    t_no_disturb(4'hA, 8'hFF, "R7 other control bits have no effect");
    t_no_disturb(4'h5, 8'h00, "R9 foreign address has no effect");
    t_same_rewrite();
    t_low_nibble();
    t_tick_gate();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule